// File: doc/BRIEF.md
# Paired-Byte Word Write Port

This block places a byte-wide host write port, decoded at a single address, in front of a memory whose entries are 16 bits wide. A sprite attribute table or a colour table is a typical target. The host delivers each word by writing the same port address twice in a row, with the even (low) byte first and the odd (high) byte second. The first byte waits in a holding latch. The second byte completes the pair, and only then does the block issue one memory write carrying both bytes.

A second host address loads the word pointer, which selects the memory entry that the next completed pair lands in. Loading the pointer also puts the port back into the low-byte phase, which gives software a known starting point. After every committed word the pointer steps forward by one and wraps at the top of the table. A behavioural model of the memory is part of the block and has a combinational lookup port so its contents can be observed.

A CPU store that is wider than a byte puts its upper byte on the next address up. The port ignores that byte, so it can never be taken as the second half of a pair.

Top module: `dwp_port`

## Requirements
- R1: After a synchronous active-high reset, `word_ptr` is 0, `mem_we` is low, and the next data-port write is treated as the low byte.
- R2: A data-port write made in the low phase issues no memory strobe and leaves every memory entry unchanged.
- R3: A data-port write made in the high phase raises `mem_we` for exactly one cycle, in the cycle after the write. In that cycle `mem_addr` carries the pointer value held at the time of the write, and `mem_wdata` is {new byte in bits 15:8, latched low byte in bits 7:0}.
- R4: Each commit advances `word_ptr` by one, modulo 2^PTR_W. The new value is visible in the same cycle as the strobe.
- R5: Any write to an address other than the data port or the pointer register has no effect on the phase, the latch, the pointer or the memory. This includes the address directly above the data port. A cycle with `wr_en` low also has no effect.
- R6: A write to the pointer register loads `wr_data[PTR_W-1:0]` into `word_ptr`, which is visible the next cycle. It also returns the port to the low phase, so a pending lone low byte is never committed.
- R7: The latched low byte is kept across any number of idle or ignored cycles. It is replaced only by the next low-phase data write.
- R8: A word that is strobed to address A can be read on `look_data` with `look_addr`=A from the cycle after the strobe onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write valid |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write byte |
| mem_we | output | 1 | Word commit strobe |
| mem_addr | output | PTR_W | Word index of the commit |
| mem_wdata | output | 16 | Committed word {high, low} |
| word_ptr | output | PTR_W | Current word pointer |
| look_addr | input | PTR_W | Memory model lookup index |
| look_data | output | 16 | Memory model lookup word |

## Verification
The bench builds the block with PTR_W=3, which gives an eight-entry table. With that size the pointer wrap from 7 to 0 happens within a handful of pairs, and a full sweep of the memory stays short. The data port sits at 0x04 and the pointer register at 0x02, so the neighbouring addresses 0x03 and 0x05 can be written to show that they are ignored. ADDR_W is kept at 8, which lets the decode compare the whole address against those values.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_DATA = 2'd1,
        HIT_PTR  = 2'd2
    } hit_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } word_t;

    function automatic phase_e flip_phase(phase_e p);
        return (p == PH_LO) ? PH_HI : PH_LO;
    endfunction

    function automatic word_t join_word(logic [7:0] lo, logic [7:0] hi);
        word_t w;
        w.hi = hi;
        w.lo = lo;
        return w;
    endfunction

endpackage

// File: rtl/dwp_decode.sv
module dwp_decode
    import dwp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] PTR_ADDR  = 8'h02
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output hit_e              hit
);
    // Full-address compare: the byte above the data port never matches.
    always_comb begin
        hit = HIT_NONE;
        if (wr_en) begin
            if (wr_addr == DATA_ADDR)
                hit = HIT_DATA;
            else if (wr_addr == PTR_ADDR)
                hit = HIT_PTR;
        end
    end
endmodule

// File: rtl/dwp_pairer.sv
module dwp_pairer
    import dwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hit_e       hit,
    input  logic [7:0] wr_data,
    output phase_e     phase,
    output logic       fire,
    output word_t      word
);
    logic [7:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LO;
            lo_q  <= '0;
        end else begin
            case (hit)
                HIT_PTR:  phase <= PH_LO;
                HIT_DATA: begin
                    phase <= flip_phase(phase);
                    if (phase == PH_LO)
                        lo_q <= wr_data;
                end
                default: ;
            endcase
        end
    end

    assign fire = (hit == HIT_DATA) && (phase == PH_HI);
    assign word = join_word(lo_q, wr_data);
endmodule

// File: rtl/dwp_pointer.sv
module dwp_pointer
    import dwp_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  hit_e             hit,
    input  logic [7:0]       wr_data,
    input  logic             fire,
    output logic [PTR_W-1:0] ptr_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (hit == HIT_PTR)
            ptr_q <= wr_data[PTR_W-1:0];
        else if (fire)
            ptr_q <= ptr_q + 1'b1;
    end
endmodule

// File: rtl/dwp_mem.sv
module dwp_mem #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] addr,
    input  logic [15:0]      wdata,
    input  logic [PTR_W-1:0] look_addr,
    output logic [15:0]      look_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign look_data = mem[look_addr];
endmodule

// File: rtl/dwp_port.sv
module dwp_port
    import dwp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PTR_W  = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] PTR_ADDR  = 8'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [PTR_W-1:0]  word_ptr,
    input  logic [PTR_W-1:0]  look_addr,
    output logic [15:0]       look_data
);
    hit_e              hit;
    phase_e            phase;
    logic              fire;
    word_t             word;
    logic [PTR_W-1:0]  ptr_q;

    logic              we_q;
    logic [PTR_W-1:0]  addr_q;
    word_t             data_q;

    dwp_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_ADDR (DATA_ADDR),
        .PTR_ADDR  (PTR_ADDR)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hit     (hit)
    );

    dwp_pairer u_pair (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .wr_data (wr_data),
        .phase   (phase),
        .fire    (fire),
        .word    (word)
    );

    dwp_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .wr_data (wr_data),
        .fire    (fire),
        .ptr_q   (ptr_q)
    );

    // Commit stage: one registered strobe per completed pair.
    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= fire;
            if (fire) begin
                addr_q <= ptr_q;
                data_q <= word;
            end
        end
    end

    dwp_mem #(.PTR_W(PTR_W)) u_mem (
        .clk       (clk),
        .we        (we_q),
        .addr      (addr_q),
        .wdata     (data_q),
        .look_addr (look_addr),
        .look_data (look_data)
    );

    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
    assign word_ptr  = ptr_q;
endmodule

// File: rtl/dwp_port_chk.sv
module dwp_port_chk
    import dwp_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input hit_e             hit,
    input phase_e           phase,
    input logic [7:0]       wr_data,
    input logic             mem_we,
    input logic [PTR_W-1:0] mem_addr,
    input logic [PTR_W-1:0] word_ptr
);
    // R2
    lo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == HIT_DATA && phase == PH_LO) |=> (!mem_we && phase == PH_HI));

    // R3
    hi_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == HIT_DATA && phase == PH_HI) |=>
            (mem_we && mem_addr == $past(word_ptr) && phase == PH_LO));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (word_ptr == PTR_W'(mem_addr + 1'b1)));

    // R5
    ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == HIT_NONE) |=> (!mem_we && $stable(phase) && $stable(word_ptr)));

    // R6
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == HIT_PTR) |=>
            (word_ptr == $past(wr_data[PTR_W-1:0]) && phase == PH_LO && !mem_we));
endmodule

bind dwp_port dwp_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .phase    (phase),
    .wr_data  (wr_data),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .word_ptr (word_ptr)
);

// File: tb/dwp_port_tb.sv
module dwp_port_tb;
    localparam int ADDR_W = 8;
    localparam int PTR_W  = 3;
    localparam int DEPTH  = 1 << PTR_W;
    localparam logic [7:0] DA = 8'h04;
    localparam logic [7:0] PA = 8'h02;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              mem_we;
    logic [PTR_W-1:0]  mem_addr;
    logic [15:0]       mem_wdata;
    logic [PTR_W-1:0]  word_ptr;
    logic [PTR_W-1:0]  look_addr = '0;
    logic [15:0]       look_data;

    always #4 clk = ~clk;

    dwp_port #(
        .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_ADDR(DA), .PTR_ADDR(PA)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .word_ptr(word_ptr),
        .look_addr(look_addr), .look_data(look_data)
    );

    typedef struct {
        logic [PTR_W-1:0] a;
        logic [15:0]      d;
    } exp_t;

    exp_t             q[$];
    int               checks = 0;
    int               errors = 0;
    logic [PTR_W-1:0] m_ptr = '0;
    logic             m_hi = 1'b0;
    logic [7:0]       m_lo = '0;
    logic [15:0]      m_mem [DEPTH];
    logic             done = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one bus write, model updated from the requirements.
    task automatic bus_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a == DA) begin
            if (!m_hi) begin
                m_lo = d; m_hi = 1'b1;
            end else begin
                q.push_back('{a: m_ptr, d: {d, m_lo}});
                m_mem[m_ptr] = {d, m_lo};
                m_ptr = m_ptr + 1'b1;
                m_hi = 1'b0;
            end
        end else if (a == PA) begin
            m_ptr = d[PTR_W-1:0];
            m_hi = 1'b0;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic look(string req, int a, logic [15:0] exp);
        look_addr = PTR_W'(a);
        #1;
        chk(req, {16'h0, look_data}, {16'h0, exp});
    endtask

    // Monitor: every strobe must match the oldest expected commit.
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected strobe actual=%h@%0d expected=none",
                         mem_wdata, mem_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3 strobe addr", {29'h0, mem_addr}, {29'h0, e.a});
                chk("R3 strobe data", {16'h0, mem_wdata}, {16'h0, e.d});
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: reset state
        chk("R1 ptr", {29'h0, word_ptr}, 32'h0);
        chk("R1 we", {31'h0, mem_we}, 32'h0);

        // R2 then R3 at pointer 0
        bus_wr(DA, 8'h11);
        chk("R2 no strobe after low", {31'h0, mem_we}, 32'h0);
        bus_wr(DA, 8'h22);
        chk("R4 ptr after commit", {29'h0, word_ptr}, {29'h0, m_ptr});
        idle(1);
        look("R8 word 0", 0, 16'h2211);

        // R6: load pointer then pair
        bus_wr(PA, 8'hF5);
        chk("R6 ptr load", {29'h0, word_ptr}, 32'h5);
        bus_wr(DA, 8'h33);
        bus_wr(DA, 8'h44);
        bus_wr(DA, 8'hAA);
        bus_wr(DA, 8'hBB);
        idle(1);
        look("R8 word 5", 5, 16'h4433);
        look("R8 word 6", 6, 16'hBBAA);

        // R2/R6: lone low byte discarded by pointer load
        bus_wr(PA, 8'h06);
        bus_wr(DA, 8'h55);
        idle(2);
        look("R2 lone byte leaves memory", 6, 16'hBBAA);
        chk("R2 ptr unchanged", {29'h0, word_ptr}, 32'h6);
        bus_wr(PA, 8'h06);
        bus_wr(DA, 8'h66);
        bus_wr(DA, 8'h77);
        idle(1);
        look("R6 phase cleared", 6, 16'h7766);

        // R5/R7: neighbours ignored, latch held across gaps
        bus_wr(DA, 8'h12);
        bus_wr(8'h05, 8'h99);
        bus_wr(8'h03, 8'h98);
        chk("R5 ptr after ignored", {29'h0, word_ptr}, 32'h7);
        chk("R5 no strobe", {31'h0, mem_we}, 32'h0);
        idle(3);
        bus_wr(DA, 8'h34);
        // R4: wrap 7 -> 0
        chk("R4 wrap", {29'h0, word_ptr}, 32'h0);
        idle(1);
        look("R7 latch held", 7, 16'h3412);

        // Sweep all entries with distinct patterns
        for (int i = 0; i < DEPTH; i++) begin
            bus_wr(DA, 8'(8'h80 + i));
            bus_wr(DA, 8'(8'h5A ^ (i * 8'h11)));
        end
        idle(2);
        chk("R4 full sweep ptr", {29'h0, word_ptr}, 32'h0);
        for (int i = 0; i < DEPTH; i++)
            look("R8 sweep", i, m_mem[i]);

        chk("R3 all commits seen", q.size(), 32'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule